// File: doc/BRIEF.md
# Fractional-Correction Baud Rate Generator

This block turns a single system clock into two periodic, single-cycle clock-enable pulses. The first pulse is the reference tick for an infrared pulse shaper, typically tuned near 1.8432 MHz. The second pulse is the bit-rate tick of a UART that oversamples by 16. Each divider has an integer divisor and a four-bit correction that adds n/16 of an input clock to the average period. A small phase accumulator produces this correction by lengthening selected periods by one clock.

Software programs the four settings through a plain write port that has an enable, a two-bit register select and a 16-bit data word. Writing a count register restarts its divider from a known phase, so the position of the first tick can be predicted. Writing a correction register takes effect at the next period boundary and leaves the current phase alone. An infrared count of zero is illegal. That divider then stops and raises a sticky error flag.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `ir_tick` and `cfg_err` are low. The infrared count is 0, so that divider is idle. The UART divider runs with count 0 and correction 0, which gives a tick every 16 clocks.
- R2: When the infrared correction is 0 and its count c is in 1..15, `ir_tick` repeats every c+1 clocks.
- R3: When the UART correction is 0, `uart_tick` repeats every (u+1)*16 clocks, where u is the UART count.
- R4: The register select values are: 0 for infrared correction, 1 for infrared count (data bits [3:0]), 2 for UART correction and 3 for UART count (data bits [11:0]). A correction is taken from data bits [7:4]. All other data bits are ignored.
- R5: Take a correction f and a base period b. Number the periods after a count write from 0; period 0 is never stretched. Period j ≥ 1 lasts b+1 clocks when floor(j·f/16) > floor((j−1)·f/16), and b clocks otherwise. As a result, any 16 consecutive periods from j = 1 contain exactly f stretched periods.
- R6: A count write clears its divider's counter and accumulator. If the write is captured at clock edge n, the first tick is high in the cycle after edge n+b−1.
- R7: Writing 0 to the infrared count holds `ir_tick` low and sets `cfg_err`. `cfg_err` stays set until reset, even after a legal count is written, and the divider then resumes normally.
- R8: Each tick is high for exactly one clock per period. It is never high in two consecutive cycles.
- R9: A correction write restarts nothing. The tick already in progress arrives at the time it would have arrived without the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (see R4) |
| wr_data | input | 16 | Write data |
| ir_tick | output | 1 | Infrared reference clock enable |
| uart_tick | output | 1 | UART bit-rate clock enable |
| cfg_err | output | 1 | Sticky flag: illegal infrared count written |

## Verification
Embedded properties check several rules on every cycle:
- each tick lasts one cycle only;
- no tick occurs in the cycle after a restart;
- each counter stays below its current period length;
- a zero correction never produces a stretched period;
- a zero infrared count keeps its tick silent;
- the error flag is set by an illegal write and stays set.

The bench sweeps every infrared count against every correction, and several UART counts against all corrections. It predicts each tick's exact cycle from floor arithmetic on j·f/16. Only these timed scenarios can show the exact dithering pattern, the phase after a count write, the correction write that leaves the current tick alone, and the masking of unused data bits.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int DATA_W   = 16;
    localparam int FRAC_W   = 4;
    localparam int FRAC_LSB = 4;
    localparam int IR_CNT_W = 4;
    localparam int OVS_LOG2 = 4;

    typedef enum logic [1:0] {
        SEL_IR_FRAC   = 2'd0,
        SEL_IR_CNT    = 2'd1,
        SEL_UART_FRAC = 2'd2,
        SEL_UART_CNT  = 2'd3
    } brg_sel_e;

    typedef logic [FRAC_W-1:0] frac_t;

    typedef struct packed {
        logic ir_frac;
        logic ir_cnt;
        logic uart_frac;
        logic uart_cnt;
    } wr_hit_t;

    function automatic frac_t pick_frac(input logic [DATA_W-1:0] d);
        return d[FRAC_LSB +: FRAC_W];
    endfunction

    function automatic wr_hit_t decode_sel(input logic en, input brg_sel_e s);
        wr_hit_t h;
        h.ir_frac   = en && (s == SEL_IR_FRAC);
        h.ir_cnt    = en && (s == SEL_IR_CNT);
        h.uart_frac = en && (s == SEL_UART_FRAC);
        h.uart_cnt  = en && (s == SEL_UART_CNT);
        return h;
    endfunction

endpackage

// File: rtl/brg_regs.sv
module brg_regs
    import brg_pkg::*;
#(
    parameter int UART_CNT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    output frac_t                 ir_frac,
    output logic [IR_CNT_W-1:0]   ir_cnt,
    output frac_t                 uart_frac,
    output logic [UART_CNT_W-1:0] uart_cnt,
    output logic                  ir_restart,
    output logic                  uart_restart,
    output logic                  cfg_err
);

    wr_hit_t hit;
    logic    ir_zero;

    assign hit     = decode_sel(wr_en, brg_sel_e'(wr_sel));
    assign ir_zero = (wr_data[IR_CNT_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_frac   <= '0;
            ir_cnt    <= '0;
            uart_frac <= '0;
            uart_cnt  <= '0;
            cfg_err   <= 1'b0;
        end else begin
            if (hit.ir_frac)   ir_frac   <= pick_frac(wr_data);
            if (hit.uart_frac) uart_frac <= pick_frac(wr_data);
            if (hit.uart_cnt)  uart_cnt  <= wr_data[UART_CNT_W-1:0];
            if (hit.ir_cnt) begin
                ir_cnt <= wr_data[IR_CNT_W-1:0];
                if (ir_zero) cfg_err <= 1'b1;
            end
        end
    end

    assign ir_restart   = hit.ir_cnt;
    assign uart_restart = hit.uart_cnt;

    // R7
    zero_cnt_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && wr_data[IR_CNT_W-1:0] == '0) |=> cfg_err);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

endmodule

// File: rtl/frac_divider.sv
module frac_divider
    import brg_pkg::*;
#(
    parameter int BASE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              enable,
    input  logic [BASE_W-1:0] base,
    input  frac_t             frac,
    output logic              tick
);

    localparam logic [BASE_W:0] ONE = (BASE_W+1)'(1);

    logic [BASE_W:0] cnt_q;
    logic [BASE_W:0] len;
    logic [BASE_W:0] last;
    frac_t           acc_q;
    logic            stretch_q;
    logic [FRAC_W:0] acc_sum;

    assign len     = {1'b0, base} + {{BASE_W{1'b0}}, stretch_q};
    assign last    = len - ONE;
    assign tick    = enable && (cnt_q == last);
    assign acc_sum = {1'b0, acc_q} + {1'b0, frac};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            stretch_q <= 1'b0;
        end else if (enable) begin
            if (tick) begin
                cnt_q     <= '0;
                acc_q     <= acc_sum[FRAC_W-1:0];
                stretch_q <= acc_sum[FRAC_W];
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    // R8
    single_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        enable |-> (cnt_q < len));

    // R5
    zero_frac_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && frac == '0) |=> !stretch_q);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import brg_pkg::*;
#(
    parameter int UART_CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ir_tick,
    output logic              uart_tick,
    output logic              cfg_err
);

    localparam int IR_BASE_W   = IR_CNT_W + 1;
    localparam int UART_MULT_W = UART_CNT_W + 1;
    localparam int UART_BASE_W = UART_MULT_W + OVS_LOG2;

    frac_t                  ir_frac, uart_frac;
    logic [IR_CNT_W-1:0]    ir_cnt;
    logic [UART_CNT_W-1:0]  uart_cnt;
    logic                   ir_restart, uart_restart;
    logic                   ir_enable;
    logic [IR_BASE_W-1:0]   ir_base;
    logic [UART_MULT_W-1:0] uart_mult;
    logic [UART_BASE_W-1:0] uart_base;

    brg_regs #(.UART_CNT_W(UART_CNT_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .ir_frac      (ir_frac),
        .ir_cnt       (ir_cnt),
        .uart_frac    (uart_frac),
        .uart_cnt     (uart_cnt),
        .ir_restart   (ir_restart),
        .uart_restart (uart_restart),
        .cfg_err      (cfg_err)
    );

    assign ir_enable = (ir_cnt != '0);
    assign ir_base   = {1'b0, ir_cnt} + {{IR_CNT_W{1'b0}}, 1'b1};
    assign uart_mult = {1'b0, uart_cnt} + {{UART_CNT_W{1'b0}}, 1'b1};
    assign uart_base = {uart_mult, {OVS_LOG2{1'b0}}};

    frac_divider #(.BASE_W(IR_BASE_W)) u_ir_div (
        .clk     (clk),
        .rst     (rst),
        .restart (ir_restart),
        .enable  (ir_enable),
        .base    (ir_base),
        .frac    (ir_frac),
        .tick    (ir_tick)
    );

    frac_divider #(.BASE_W(UART_BASE_W)) u_uart_div (
        .clk     (clk),
        .rst     (rst),
        .restart (uart_restart),
        .enable  (1'b1),
        .base    (uart_base),
        .frac    (uart_frac),
        .tick    (uart_tick)
    );

    // R7
    ir_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_cnt == '0) |-> !ir_tick);

endmodule

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        ir_tick, uart_tick, cfg_err;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frac_baud_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ir_tick   (ir_tick),
        .uart_tick (uart_tick),
        .cfg_err   (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // the edge that captures the write has number w, read at the following negedge
    task automatic wr(input int a, input int d, output int w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = 2'(a);
        wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
        w = cyc;
    endtask

    task automatic wait_tick(input bit sel_ir, input int exp, input string req);
        bit tk;
        forever begin
            @(negedge clk);
            tk = sel_ir ? ir_tick : uart_tick;
            if (cyc >= exp) break;
            if (tk) chk(1'b0, {req, " early tick"}, cyc, exp);
        end
        chk(tk && cyc == exp, req, tk ? cyc : -1, exp);
    endtask

    task automatic run(input bit sel_ir, input int base, input int f,
                       input int w, input int nper, input string req);
        int exp;
        exp = w + base - 1;
        for (int k = 0; k < nper; k++) begin
            wait_tick(sel_ir, exp, req);
            exp += base + ((k + 1) * f) / 16 - (k * f) / 16;
        end
    endtask

    initial begin
        int w;
        int t1;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(cfg_err == 1'b0, "R1 cfg_err after reset", cfg_err, 0);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ir_tick) bad++;
        end
        chk(bad == 0, "R1 ir_tick idle after reset", bad, 0);
        t1 = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (uart_tick) begin t1 = cyc; break; end
        end
        chk(t1 >= 0, "R1 uart tick present", t1, 0);
        run(1'b0, 16, 0, t1 + 1, 2, "R1 uart period 16");

        // R6: first tick position after count write, R9: correction write keeps phase
        wr(0, 16'h0000, w);
        wr(1, 16'h0007, w);
        run(1'b1, 8, 0, w, 1, "R6 first tick after count write");
        wr(0, 16'h00F0, t1);
        wait_tick(1'b1, w + 15, "R9 correction write keeps phase");
        wait_tick(1'b1, w + 23, "R9 next period unstretched");
        wait_tick(1'b1, w + 32, "R9 stretch after accumulator wraps");

        // R4: unused data bits ignored on both write types
        wr(0, 16'hFF5F, w);
        wr(1, 16'hABC3, w);
        run(1'b1, 4, 5, w, 17, "R4 masked fields");

        // R2 and R5: every infrared count against every correction
        for (int c = 1; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                wr(0, 16'hFF0F | (f << 4), w);
                wr(1, 16'hABC0 | c, w);
                run(1'b1, c + 1, f, w, 17, (f == 0) ? "R2 ir period" : "R5 ir dithering");
            end
        end

        // R3 and R5: UART divider
        for (int c = 0; c < 2; c++) begin
            for (int f = 0; f < 16; f++) begin
                wr(2, 16'h3A0C | (f << 4), w);
                wr(3, 16'hF000 | c, w);
                run(1'b0, (c + 1) * 16, f, w, 17, (f == 0) ? "R3 uart period" : "R5 uart dithering");
            end
        end
        wr(2, 16'h0000, w);
        wr(3, 16'h0002, w);
        run(1'b0, 48, 0, w, 4, "R3 uart count 2");
        wr(2, 16'h0090, w);
        wr(3, 16'h00FF, w);
        run(1'b0, 4096, 9, w, 3, "R5 large uart count");

        // R8: single-cycle ticks over a long window
        wr(0, 16'h00F0, w);
        wr(1, 16'h0001, w);
        bad = 0;
        t1 = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ir_tick && t1 == 1) bad++;
            t1 = ir_tick ? 1 : 0;
        end
        chk(bad == 0, "R8 no back-to-back ir ticks", bad, 0);
        chk(cfg_err == 1'b0, "R7 no error from legal counts", cfg_err, 0);

        // R7: illegal zero count
        wr(0, 16'h0000, w);
        wr(1, 16'hFFF0, w);
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (ir_tick) bad++;
        end
        chk(bad == 0, "R7 ir_tick held low", bad, 0);
        chk(cfg_err == 1'b1, "R7 cfg_err set", cfg_err, 1);
        wr(1, 16'h0002, w);
        run(1'b1, 3, 0, w, 5, "R7 resumes after legal count");
        chk(cfg_err == 1'b1, "R7 cfg_err sticky", cfg_err, 1);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule